// File: doc/BRIEF.md
# Two-Instruction 64-bit Integer Core

This block is a small, single-issue 64-bit integer core. It takes one 32-bit instruction word per step from the bench or the surrounding logic. It decodes the word and runs it against a 32-entry, 64-bit register file. It recognises two operations: add-immediate and load-doubleword. Every other encoding is rejected as illegal.

Add-immediate completes in the cycle its word is accepted. A load computes its effective address and checks that the address is aligned to 8 bytes. It then holds a request on a data-read port until the memory answers with a valid strobe. A faulting instruction changes no register and does not move the program counter. It sets a sticky error flag with a cause code and the core keeps running.

Each completed instruction gives a one-cycle retire pulse. The pulse carries the destination index and the value written, so register contents can be seen from outside.

Top module: `mini64_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core is cleared: `pc_o` becomes `RESET_VEC`, `err_flag`, `err_cause`, `retire_valid` and `dmem_req` become 0, `insn_ready` becomes 1, and all 32 registers read as zero.
- R2: A word with bits [6:0] = 0010011 and bits [14:12] = 000 is an add-immediate. It writes rs1 (bits [19:15]) plus the sign-extended 12-bit immediate (bits [31:20]) to rd (bits [11:7]), and it retires at the next rising edge.
- R3: Register 0 always reads as zero. Writes to it are dropped, and a retire whose `retire_rd` is 0 reports `retire_data` = 0.
- R4: A word with bits [6:0] = 0000011 and bits [14:12] = 011 is a load-doubleword. Its address is rs1 plus the sign-extended immediate. `dmem_req` stays high and `dmem_addr` stays stable until `dmem_valid`. The 64-bit `dmem_rdata` is then written to rd, with the byte at address A+i in bits [8i+7:8i].
- R5: A load whose address is not a multiple of 8 makes no memory request and writes no register. It records cause 2 (misaligned).
- R6: Any other word, including the two opcodes with any other bits [14:12], writes no register. It records cause 1 (illegal).
- R7: `err_flag` is sticky until reset. `err_cause` keeps the cause of the first fault (0 = none). The core keeps accepting instructions after a fault.
- R8: Each completed instruction raises `retire_valid` for one cycle, together with `retire_rd` and `retire_data`, and adds 4 to `pc_o` at the same edge. A faulting instruction leaves `pc_o` unchanged.
- R9: `insn_ready` is low while a load waits for its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 64 | Program counter |
| insn_valid | input | 1 | Instruction word offered |
| insn_word | input | 32 | Instruction word |
| insn_ready | output | 1 | Core can accept a word this cycle |
| dmem_req | output | 1 | Data read request |
| dmem_addr | output | 64 | Data read address, 8-byte aligned |
| dmem_valid | input | 1 | Read data valid |
| dmem_rdata | input | 64 | Read data, little-endian byte lanes |
| retire_valid | output | 1 | One-cycle retire pulse |
| retire_rd | output | 5 | Destination of the retired instruction |
| retire_data | output | 64 | Value written by the retired instruction |
| err_flag | output | 1 | Sticky fault flag |
| err_cause | output | 2 | First fault cause: 0 none, 1 illegal, 2 misaligned |

## Verification
Some properties are checked on every cycle:
- the program counter moves by exactly 4 on a retire and holds otherwise;
- a retire to register 0 reports zero;
- the error flag and its cause never change once set;
- a pending read keeps its address stable and aligned;
- the core refuses words while a read is pending.

Other behaviour can only be shown by the bench's scenarios:
- the arithmetic of add-immediate over all 4096 immediates;
- the fields decoded from each word;
- the load data reaching the right register;
- a faulting instruction leaving its destination register untouched.

// File: rtl/mini64_pkg.sv
package mini64_pkg;

    localparam int XLEN    = 64;
    localparam int ILEN    = 32;
    localparam int REG_CNT = 32;
    localparam int IDX_W   = $clog2(REG_CNT);
    localparam int IMM_W   = 12;

    localparam logic [6:0] OPC_OPIMM = 7'b0010011;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [2:0] F3_ADDI   = 3'b000;
    localparam logic [2:0] F3_LDW    = 3'b011;

    typedef enum logic [1:0] {
        OP_ADDI = 2'd0,
        OP_LD   = 2'd1,
        OP_BAD  = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_ILLEGAL  = 2'd1,
        CAUSE_MISALIGN = 2'd2
    } cause_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

    typedef struct packed {
        op_e               op;
        logic [IDX_W-1:0]  rd;
        logic [IDX_W-1:0]  rs1;
        logic [XLEN-1:0]   imm;
    } dec_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/mini64_decode.sv
module mini64_decode
    import mini64_pkg::*;
(
    input  logic [ILEN-1:0] word,
    output dec_t            dec
);
    logic [6:0] opcode;
    logic [2:0] funct3;

    assign opcode = word[6:0];
    assign funct3 = word[14:12];

    always_comb begin
        dec.rd  = word[11:7];
        dec.rs1 = word[19:15];
        dec.imm = sext_imm(word[31:20]);
        if (opcode == OPC_OPIMM && funct3 == F3_ADDI)
            dec.op = OP_ADDI;
        else if (opcode == OPC_LOAD && funct3 == F3_LDW)
            dec.op = OP_LD;
        else
            dec.op = OP_BAD;
    end
endmodule

// File: rtl/mini64_regfile.sv
module mini64_regfile
    import mini64_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_val
);
    logic [XLEN-1:0] regs [REG_CNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
        end else if (wr_en && wr_idx != '0) begin
            regs[wr_idx] <= wr_val;
        end
    end

    assign rd_val = (rd_idx == '0) ? '0 : regs[rd_idx];
endmodule

// File: rtl/mini64_agu.sv
module mini64_agu
    import mini64_pkg::*;
#(
    parameter int ACC_BYTES = 8
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] sum,
    output logic            misaligned
);
    localparam int LOW_W = $clog2(ACC_BYTES);

    assign sum = base + offset;

    generate
        if (LOW_W == 0) begin : g_byte
            assign misaligned = 1'b0;
        end else begin : g_wide
            assign misaligned = |sum[LOW_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/mini64_core.sv
module mini64_core
    import mini64_pkg::*;
#(
    parameter logic [63:0] RESET_VEC = 64'h0000_0000_8000_0000,
    parameter int          LD_BYTES  = 8
) (
    input  logic        clk,
    input  logic        rst,
    output logic [63:0] pc_o,
    input  logic        insn_valid,
    input  logic [31:0] insn_word,
    output logic        insn_ready,
    output logic        dmem_req,
    output logic [63:0] dmem_addr,
    input  logic        dmem_valid,
    input  logic [63:0] dmem_rdata,
    output logic        retire_valid,
    output logic [4:0]  retire_rd,
    output logic [63:0] retire_data,
    output logic        err_flag,
    output logic [1:0]  err_cause
);
    dec_t             dec;
    logic [XLEN-1:0]  rs1_val;
    logic [XLEN-1:0]  agu_sum;
    logic             agu_mis;

    state_e           state_q;
    logic [XLEN-1:0]  pc_q;
    logic [XLEN-1:0]  ld_addr_q;
    logic [IDX_W-1:0] ld_rd_q;
    logic             err_q;
    cause_e           cause_q;
    logic             ret_v_q;
    logic [IDX_W-1:0] ret_rd_q;
    logic [XLEN-1:0]  ret_data_q;

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [XLEN-1:0]  wr_val;
    logic             retire_now;
    logic             go_wait;
    logic             fault;
    cause_e           fault_cause;

    mini64_decode u_dec (
        .word (insn_word),
        .dec  (dec)
    );

    mini64_regfile u_rf (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (dec.rs1),
        .rd_val (rs1_val),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_val (wr_val)
    );

    mini64_agu #(.ACC_BYTES(LD_BYTES)) u_agu (
        .base       (rs1_val),
        .offset     (dec.imm),
        .sum        (agu_sum),
        .misaligned (agu_mis)
    );

    always_comb begin
        wr_en       = 1'b0;
        wr_idx      = dec.rd;
        wr_val      = agu_sum;
        retire_now  = 1'b0;
        go_wait     = 1'b0;
        fault       = 1'b0;
        fault_cause = CAUSE_NONE;
        if (state_q == ST_RUN && insn_valid) begin
            case (dec.op)
                OP_ADDI: begin
                    wr_en      = 1'b1;
                    retire_now = 1'b1;
                end
                OP_LD: begin
                    if (agu_mis) begin
                        fault       = 1'b1;
                        fault_cause = CAUSE_MISALIGN;
                    end else begin
                        go_wait = 1'b1;
                    end
                end
                default: begin
                    fault       = 1'b1;
                    fault_cause = CAUSE_ILLEGAL;
                end
            endcase
        end else if (state_q == ST_WAIT && dmem_valid) begin
            wr_en      = 1'b1;
            wr_idx     = ld_rd_q;
            wr_val     = dmem_rdata;
            retire_now = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_RUN;
            pc_q       <= RESET_VEC;
            ld_addr_q  <= '0;
            ld_rd_q    <= '0;
            err_q      <= 1'b0;
            cause_q    <= CAUSE_NONE;
            ret_v_q    <= 1'b0;
            ret_rd_q   <= '0;
            ret_data_q <= '0;
        end else begin
            ret_v_q <= retire_now;
            if (retire_now) begin
                ret_rd_q   <= wr_idx;
                ret_data_q <= (wr_idx == '0) ? '0 : wr_val;
                pc_q       <= pc_q + 64'd4;
            end
            if (go_wait) begin
                state_q   <= ST_WAIT;
                ld_rd_q   <= dec.rd;
                ld_addr_q <= agu_sum;
            end else if (state_q == ST_WAIT && dmem_valid) begin
                state_q <= ST_RUN;
            end
            if (fault && !err_q) begin
                err_q   <= 1'b1;
                cause_q <= fault_cause;
            end
        end
    end

    assign pc_o         = pc_q;
    assign insn_ready   = (state_q == ST_RUN);
    assign dmem_req     = (state_q == ST_WAIT);
    assign dmem_addr    = ld_addr_q;
    assign retire_valid = ret_v_q;
    assign retire_rd    = ret_rd_q;
    assign retire_data  = ret_data_q;
    assign err_flag     = err_q;
    assign err_cause    = cause_q;
endmodule

// File: rtl/mini64_core_sva.sv
module mini64_core_sva #(
    parameter int LD_BYTES = 8
) (
    input logic        clk,
    input logic        rst,
    input logic [63:0] pc_o,
    input logic        insn_ready,
    input logic        dmem_req,
    input logic [63:0] dmem_addr,
    input logic        dmem_valid,
    input logic        retire_valid,
    input logic [4:0]  retire_rd,
    input logic [63:0] retire_data,
    input logic        err_flag,
    input logic [1:0]  err_cause
);
    a_r3_x0_reports_zero: assert property (@(posedge clk) disable iff (rst)
        (retire_valid && retire_rd == 5'd0) |-> retire_data == 64'd0);

    a_r8_pc_steps_on_retire: assert property (@(posedge clk) disable iff (rst)
        retire_valid |-> pc_o == $past(pc_o) + 64'd4);

    a_r8_pc_holds_otherwise: assert property (@(posedge clk) disable iff (rst)
        !retire_valid |-> pc_o == $past(pc_o));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    a_r7_cause_kept: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> $stable(err_cause));

    a_r7_cause_coded: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> (err_cause == 2'd1 || err_cause == 2'd2));

    a_r7_no_cause_without_flag: assert property (@(posedge clk) disable iff (rst)
        !err_flag |-> err_cause == 2'd0);

    a_r6_fault_does_not_retire: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> !retire_valid);

    a_r4_request_held: assert property (@(posedge clk) disable iff (rst)
        (dmem_req && !dmem_valid) |=> (dmem_req && $stable(dmem_addr)));

    a_r5_request_aligned: assert property (@(posedge clk) disable iff (rst)
        dmem_req |-> (dmem_addr % 64'(LD_BYTES)) == 64'd0);

    a_r9_busy_while_loading: assert property (@(posedge clk) disable iff (rst)
        dmem_req |-> !insn_ready);
endmodule

bind mini64_core mini64_core_sva #(.LD_BYTES(LD_BYTES)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .pc_o         (pc_o),
    .insn_ready   (insn_ready),
    .dmem_req     (dmem_req),
    .dmem_addr    (dmem_addr),
    .dmem_valid   (dmem_valid),
    .retire_valid (retire_valid),
    .retire_rd    (retire_rd),
    .retire_data  (retire_data),
    .err_flag     (err_flag),
    .err_cause    (err_cause)
);

// File: tb/mini64_core_tb.sv
`timescale 1ns/1ps
module mini64_core_tb_top;
    localparam logic [63:0] RV = 64'h0000_0000_8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] pc_o;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        insn_ready;
    logic        dmem_req;
    logic [63:0] dmem_addr;
    logic        dmem_valid = 1'b0;
    logic [63:0] dmem_rdata = '0;
    logic        retire_valid;
    logic [4:0]  retire_rd;
    logic [63:0] retire_data;
    logic        err_flag;
    logic [1:0]  err_cause;

    always #2 clk = ~clk;

    mini64_core #(.RESET_VEC(RV), .LD_BYTES(8)) dut_i (
        .clk(clk), .rst(rst), .pc_o(pc_o),
        .insn_valid(insn_valid), .insn_word(insn_word), .insn_ready(insn_ready),
        .dmem_req(dmem_req), .dmem_addr(dmem_addr),
        .dmem_valid(dmem_valid), .dmem_rdata(dmem_rdata),
        .retire_valid(retire_valid), .retire_rd(retire_rd), .retire_data(retire_data),
        .err_flag(err_flag), .err_cause(err_cause)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [63:0] mdl [32];
    logic [63:0] mpc;
    logic        merr;
    logic [1:0]  mcause;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [11:0] imm, input int rs1,
                                        input logic [2:0] f3, input int rd,
                                        input logic [6:0] opc);
        return {imm, 5'(rs1), f3, 5'(rd), opc};
    endfunction

    function automatic logic [63:0] sx(input logic [11:0] v);
        return {{52{v[11]}}, v};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; insn_valid = 1'b0; dmem_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        mpc = RV; merr = 1'b0; mcause = 2'd0;
    endtask

    task automatic do_addi(input string tag, input int rd, input int rs1, input logic [11:0] imm);
        logic [63:0] exp;
        exp = (rd == 0) ? 64'd0 : mdl[rs1] + sx(imm);
        @(negedge clk);
        insn_word = enc(imm, rs1, 3'b000, rd, 7'b0010011);
        insn_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        insn_valid = 1'b0;
        mpc = mpc + 64'd4;
        chk(tag, "retire_valid", {63'd0, retire_valid}, 64'd1);
        chk(tag, "retire_rd", {59'd0, retire_rd}, 64'(rd));
        chk(tag, "retire_data", retire_data, exp);
        chk("R8", "pc", pc_o, mpc);
        if (rd != 0) mdl[rd] = exp;
    endtask

    task automatic do_ld(input string tag, input int rd, input int rs1, input logic [11:0] imm,
                         input logic [63:0] data, input int waitc);
        logic [63:0] ea;
        ea = mdl[rs1] + sx(imm);
        @(negedge clk);
        insn_word = enc(imm, rs1, 3'b011, rd, 7'b0000011);
        insn_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        insn_valid = 1'b0;
        chk(tag, "dmem_req", {63'd0, dmem_req}, 64'd1);
        chk(tag, "dmem_addr", dmem_addr, ea);
        chk("R9", "insn_ready", {63'd0, insn_ready}, 64'd0);
        for (int w = 0; w < waitc; w++) begin
            @(negedge clk);
            chk(tag, "dmem_req held", {63'd0, dmem_req}, 64'd1);
            chk(tag, "dmem_addr held", dmem_addr, ea);
        end
        dmem_valid = 1'b1;
        dmem_rdata = data;
        @(posedge clk);
        @(negedge clk);
        dmem_valid = 1'b0;
        mpc = mpc + 64'd4;
        chk(tag, "retire_valid", {63'd0, retire_valid}, 64'd1);
        chk(tag, "retire_rd", {59'd0, retire_rd}, 64'(rd));
        chk(tag, "retire_data", retire_data, (rd == 0) ? 64'd0 : data);
        chk("R8", "pc", pc_o, mpc);
        if (rd != 0) mdl[rd] = data;
    endtask

    task automatic do_fault(input string tag, input logic [31:0] word, input logic [1:0] cause);
        @(negedge clk);
        insn_word = word;
        insn_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        insn_valid = 1'b0;
        if (!merr) begin merr = 1'b1; mcause = cause; end
        chk(tag, "no retire", {63'd0, retire_valid}, 64'd0);
        chk(tag, "no request", {63'd0, dmem_req}, 64'd0);
        chk(tag, "err_flag", {63'd0, err_flag}, 64'd1);
        chk(tag, "err_cause", {62'd0, err_cause}, {62'd0, mcause});
        chk("R8", "pc held on fault", pc_o, mpc);
        chk("R7", "insn_ready after fault", {63'd0, insn_ready}, 64'd1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state at the ports
        do_reset();
        chk("R1", "pc", pc_o, RV);
        chk("R1", "err_flag", {63'd0, err_flag}, 64'd0);
        chk("R1", "err_cause", {62'd0, err_cause}, 64'd0);
        chk("R1", "retire_valid", {63'd0, retire_valid}, 64'd0);
        chk("R1", "dmem_req", {63'd0, dmem_req}, 64'd0);
        chk("R1", "insn_ready", {63'd0, insn_ready}, 64'd1);

        // R2: every 12-bit immediate from x0, spread over all destinations
        for (int i = 0; i < 4096; i++) do_addi("R2", 1 + (i % 31), 0, 12'(i));
        // R2: accumulate in one register through nonzero rs1
        for (int i = 0; i < 512; i++) do_addi("R2", 7, 7, 12'(i * 13 - 2048));
        do_addi("R2", 12, 7, 12'h801);

        // R3: writes to x0 dropped, x0 reads zero
        do_addi("R3", 0, 5, 12'd123);
        do_addi("R3", 13, 0, 12'd0);

        // R1: reset clears every register
        do_reset();
        for (int r = 0; r < 32; r++) do_addi("R1", 1, r, 12'd0);

        // R4: aligned loads around a base, varying wait
        do_addi("R4", 1, 0, 12'h400);
        for (int k = -32; k <= 32; k++)
            do_ld("R4", 2 + ((k + 32) % 8), 1, 12'(k * 8),
                  64'h0706050403020100 + 64'(k + 40) * 64'h0101010101010101, (k + 32) % 4);
        do_ld("R4", 2, 1, 12'd16, 64'h8877665544332211, 2);
        chk("R4", "byte lane 0", {56'd0, retire_data[7:0]}, 64'h11);
        chk("R4", "byte lane 7", {56'd0, retire_data[63:56]}, 64'h88);
        do_addi("R4", 10, 2, 12'd0);
        do_ld("R3", 0, 1, 12'd8, 64'hDEADBEEFCAFEF00D, 1);
        do_addi("R3", 11, 0, 12'd0);

        // R5: misaligned loads fault with cause 2 and leave rd alone
        do_reset();
        do_addi("R5", 1, 0, 12'h400);
        do_addi("R5", 2, 0, 12'd55);
        for (int off = 1; off < 8; off++) begin
            do_fault("R5", enc(12'(off), 1, 3'b011, 2, 7'b0000011), 2'd2);
            do_addi("R5", 10, 2, 12'd0);
        end
        do_fault("R5", enc(12'hFFF, 1, 3'b011, 2, 7'b0000011), 2'd2);
        do_addi("R5", 10, 2, 12'd0);

        // R7: reset clears the sticky flag
        do_reset();
        chk("R7", "err cleared by reset", {63'd0, err_flag}, 64'd0);

        // R6: illegal encodings, cause 1, rd untouched
        do_addi("R6", 3, 0, 12'd77);
        do_addi("R6", 1, 0, 12'h400);
        for (int f = 1; f < 8; f++) begin
            do_fault("R6", enc(12'd5, 0, 3'(f), 3, 7'b0010011), 2'd1);
            do_addi("R6", 11, 3, 12'd0);
        end
        for (int f = 0; f < 8; f++) begin
            if (f != 3) begin
                do_fault("R6", enc(12'd0, 1, 3'(f), 3, 7'b0000011), 2'd1);
                do_addi("R6", 11, 3, 12'd0);
            end
        end
        do_fault("R6", 32'h0000_0000, 2'd1);
        do_fault("R6", 32'hFFFF_FFFF, 2'd1);
        do_fault("R6", enc(12'd0, 1, 3'b000, 3, 7'b0110011), 2'd1);
        do_addi("R6", 11, 3, 12'd0);

        // R7: a later misaligned fault keeps the first cause
        do_fault("R7", enc(12'd3, 1, 3'b011, 3, 7'b0000011), 2'd2);
        chk("R7", "first cause kept", {62'd0, err_cause}, 64'd1);
        do_ld("R7", 4, 1, 12'd0, 64'h0123456789ABCDEF, 0);

        finish_run();
    end
endmodule